// File: doc/BRIEF.md
# Programmable Hard-Decision Viterbi Decoder

This block decodes a rate-1/2 convolutional code of constraint length 7 as a continuous stream. On each cycle that the input qualifier is high it accepts two hard code bits, advances a 64-state trellis by one step, and, once enough history is held, emits one decoded data bit. The two 7-bit generator polynomials sit in configuration registers that can be rewritten at run time. The expected code pair of every trellis branch is computed from these registers rather than from fixed taps, so any rate-1/2, K=7 code can be decoded without changing the logic.

Internally a branch unit forms the Hamming distance for all 128 transitions. An add-compare-select array keeps one wrapping path metric per state and produces one survivor decision per state. A survivor history of 42 steps is traced back from the state with the best metric, and the oldest bit on that path is released. The encoder is assumed to start in the all-zero state after reset.

Top module: `vit_decoder_top`

## Requirements
- R1: The trellis state holds the last six data bits, with state bit 5 the newest. For a transition that shifts data bit u into state s, the expected code bit for each generator is the XOR-reduction of the generator ANDed with {u, s}. In that 7-bit value bit 6 is u and bit 0 is the oldest state bit. `in_sym_a` is compared against generator A and `in_sym_b` against generator B.
- R2: The branch metric is the Hamming distance (0, 1 or 2) between the received pair and the expected pair. Each state keeps the smaller of its two candidate sums, and a tie selects the even-numbered predecessor.
- R3: A cycle with `cfg_load` high captures `cfg_poly_a` and `cfg_poly_b`, and the next accepted pair uses them. Reset loads 171 and 133 (octal) as generators A and B.
- R4: With generators 171/133, random data, and at most one flipped code bit in any 32 consecutive code bits, the decoded stream equals the encoder input.
- R5: After a synchronous active-low reset, `out_valid` and `out_bit` are 0. State 0 has metric 0 and every other state has a bias metric, so the smallest metric is 0.
- R6: The first data bit appears on `out_bit` with `out_valid` high in the cycle after the 44th accepted pair. Each later accepted pair releases the next data bit in order, one cycle after that pair.
- R7: A cycle with `in_valid` low does not advance the trellis. In the following cycle `out_valid` is low, `out_bit` keeps its value, and the path metrics are unchanged.
- R8: Between consecutive accepted pairs the smallest path metric grows by 0, 1 or 2, counted modulo 2^MW.
- R9: Path metrics wrap without renormalisation, and decoding stays correct after the smallest metric has passed 2^MW.
- R10: After the generators are reprogrammed to 165 and 117 (octal), an error-free stream encoded with them decodes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Load strobe for both generator registers |
| cfg_poly_a | input | K | Generator A, bit K-1 weights the new data bit |
| cfg_poly_b | input | K | Generator B, same bit order |
| in_valid | input | 1 | Qualifies the received code pair |
| in_sym_a | input | 1 | Hard code bit for generator A |
| in_sym_b | input | 1 | Hard code bit for generator B |
| out_valid | output | 1 | A decoded bit is present |
| out_bit | output | 1 | Decoded data bit |

## Verification
The decoder's results become visible one clock after the accepted pair that releases them. The first data bit is due in the cycle after the 44th accepted pair, and each following bit comes one cycle after the next accepted pair. Idle cycles add no output and move no result. The bench drives inputs on the falling edge and checks at the next falling edge. It keeps a queue of the data bits it encoded and a count of accepted pairs, and from these it predicts on every clock whether a bit is due and which one it is. A configuration load takes effect on the first pair accepted after the strobe, so the bench loads the new generators in a cycle with no input before it sends the stream encoded with them.

// File: rtl/vit_pkg.sv
// Shared helpers for the Viterbi decoder.
// Assumes hard-decision inputs and a rate-1/2 code.
package vit_pkg;

    // Default code parameters.
    localparam int unsigned VIT_K_DEF  = 7;
    localparam int unsigned VIT_TB_DEF = 42;

    // Expected code bit: parity of generator taps over the shift register.
    function automatic logic code_bit(input logic [31:0] poly, input logic [31:0] regv);
        return ^(poly & regv);
    endfunction

    // Hamming distance between two 1-bit symbols, widened to 2 bits.
    function automatic logic [1:0] ham1(input logic x, input logic y);
        return {1'b0, x ^ y};
    endfunction

endpackage

// File: rtl/vit_branch_unit.sv
// Branch metric unit.
// Computes the Hamming distance between the received pair and the
// expected pair for every one of the 2^K transitions. Index j is the
// K-bit register {new bit, previous state}.
// Assumes the generators are stable while a pair is being scored.
module vit_branch_unit
    import vit_pkg::*;
#(
    parameter int K = 7
) (
    input  logic [K-1:0]              poly_a,
    input  logic [K-1:0]              poly_b,
    input  logic                      sym_a,
    input  logic                      sym_b,
    output logic [(2**K)-1:0][1:0]    bm_o
);
    localparam int NB = 2**K;

    for (genvar j = 0; j < NB; j++) begin : g_br
        logic exp_a;
        logic exp_b;
        // Expected code pair for this transition.
        always_comb begin
            exp_a = code_bit(32'(poly_a), 32'(j));
            exp_b = code_bit(32'(poly_b), 32'(j));
        end
        // Distance to the received pair.
        assign bm_o[j] = ham1(exp_a, sym_a) + ham1(exp_b, sym_b);
    end
endmodule

// File: rtl/vit_acs_array.sv
// Add-compare-select array with path metric storage.
// Next state n is reached from predecessors {n[M-2:0],0} and {n[M-2:0],1}
// on branch index {n,b}. Metrics are compared modulo 2^W by the sign of
// their difference. A tie keeps the even predecessor (decision 0).
// Assumes the metric spread stays below 2^(W-1).
module vit_acs_array #(
    parameter int K    = 7,
    parameter int W    = 8,
    parameter int BIAS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv,
    input  logic [(2**K)-1:0][1:0]     bm_i,
    output logic [(2**(K-1))-1:0][W-1:0] pm_o,
    output logic [(2**(K-1))-1:0]      dec_o
);
    localparam int NS = 2**(K-1);

    logic [NS-1:0][W-1:0] pm_q;
    logic [NS-1:0][W-1:0] pm_d;

    for (genvar s = 0; s < NS; s++) begin : g_acs
        localparam int P0 = (2 * s) % NS;
        localparam int P1 = P0 + 1;
        logic [W-1:0] cand0;
        logic [W-1:0] cand1;
        logic [W-1:0] diff;
        // Add both candidates and pick the smaller one.
        always_comb begin
            cand0    = pm_q[P0] + W'(bm_i[2*s]);
            cand1    = pm_q[P1] + W'(bm_i[2*s+1]);
            diff     = cand1 - cand0;
            dec_o[s] = diff[W-1];
            pm_d[s]  = diff[W-1] ? cand1 : cand0;
        end
        // Metric register: start in state 0, update on accepted pairs.
        always_ff @(posedge clk) begin
            if (!rst_n)   pm_q[s] <= (s == 0) ? '0 : W'(BIAS);
            else if (adv) pm_q[s] <= pm_d[s];
        end
    end

    assign pm_o = pm_q;
endmodule

// File: rtl/vit_traceback.sv
// Survivor history and traceback.
// Keeps the last D decision vectors, newest in slot 0. Each cycle it finds
// the state with the smallest metric (lowest index wins on ties), follows
// the decisions back D steps and reports the data bit of the state reached.
// Assumes pm_i and dec_i describe the same trellis step.
module vit_traceback #(
    parameter int K = 7,
    parameter int D = 42,
    parameter int W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         adv,
    input  logic [(2**(K-1))-1:0]        dec_i,
    input  logic [(2**(K-1))-1:0][W-1:0] pm_i,
    output logic                         tb_bit_o,
    output logic [W-1:0]                 best_metric_o
);
    localparam int M  = K - 1;
    localparam int NS = 2**M;

    logic [D-1:0][NS-1:0] hist_q;
    logic [M-1:0]         best_idx;
    logic [W-1:0]         best_val;
    logic [W-1:0]         diff;
    logic [M-1:0]         st;

    // Shift the decision history on each accepted pair.
    always_ff @(posedge clk) begin
        if (!rst_n)   hist_q <= '0;
        else if (adv) hist_q <= {hist_q[D-2:0], dec_i};
    end

    // Find the best state by a modulo comparison.
    always_comb begin
        best_idx = '0;
        best_val = pm_i[0];
        diff     = '0;
        for (int s = 1; s < NS; s++) begin
            diff = pm_i[s] - best_val;
            if (diff[W-1]) begin
                best_val = pm_i[s];
                best_idx = M'(s);
            end
        end
    end

    // Walk the survivor path back D steps.
    always_comb begin
        st = best_idx;
        for (int i = 0; i < D; i++) begin
            st = {st[M-2:0], hist_q[i][st]};
        end
    end

    assign tb_bit_o      = st[M-1];
    assign best_metric_o = best_val;
endmodule

// File: rtl/vit_decoder_top.sv
// Programmable rate-1/2 hard-decision Viterbi decoder, top level.
// Holds the generator registers, the fill counter and the output register.
// An accepted pair releases a decoded bit once D+1 pairs came before it.
// Assumes the encoder starts in the all-zero state after reset.
module vit_decoder_top #(
    parameter int         K          = vit_pkg::VIT_K_DEF,
    parameter int         TB_DEPTH   = vit_pkg::VIT_TB_DEF,
    parameter int         MW         = 8,
    parameter int         BIAS       = 32,
    parameter logic [K-1:0] POLY_A_RST = 7'o171,
    parameter logic [K-1:0] POLY_B_RST = 7'o133
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_load,
    input  logic [K-1:0] cfg_poly_a,
    input  logic [K-1:0] cfg_poly_b,
    input  logic         in_valid,
    input  logic         in_sym_a,
    input  logic         in_sym_b,
    output logic         out_valid,
    output logic         out_bit
);
    localparam int NS   = 2**(K-1);
    localparam int NB   = 2**K;
    localparam int FULL = TB_DEPTH + 1;
    localparam int FW   = $clog2(FULL + 1);

    logic [K-1:0]           poly_a_q;
    logic [K-1:0]           poly_b_q;
    logic [FW-1:0]          fill_q;
    logic [NB-1:0][1:0]     bm;
    logic [NS-1:0][MW-1:0]  pm;
    logic [NS-1:0]          dec;
    logic                   tb_bit;
    logic [MW-1:0]          best_metric;

    // Generator registers, loaded by strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poly_a_q <= POLY_A_RST;
            poly_b_q <= POLY_B_RST;
        end else if (cfg_load) begin
            poly_a_q <= cfg_poly_a;
            poly_b_q <= cfg_poly_b;
        end
    end

    // Count accepted pairs until the traceback window is full.
    always_ff @(posedge clk) begin
        if (!rst_n)                             fill_q <= '0;
        else if (in_valid && fill_q != FW'(FULL)) fill_q <= fill_q + 1'b1;
    end

    // Output register: one bit per accepted pair once the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= in_valid && (fill_q == FW'(FULL));
            if (in_valid && (fill_q == FW'(FULL))) out_bit <= tb_bit;
        end
    end

    vit_branch_unit #(.K(K)) u_bmu (
        .poly_a (poly_a_q),
        .poly_b (poly_b_q),
        .sym_a  (in_sym_a),
        .sym_b  (in_sym_b),
        .bm_o   (bm)
    );

    vit_acs_array #(.K(K), .W(MW), .BIAS(BIAS)) u_acs (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .bm_i  (bm),
        .pm_o  (pm),
        .dec_o (dec)
    );

    vit_traceback #(.K(K), .D(TB_DEPTH), .W(MW)) u_tb (
        .clk           (clk),
        .rst_n         (rst_n),
        .adv           (in_valid),
        .dec_i         (dec),
        .pm_i          (pm),
        .tb_bit_o      (tb_bit),
        .best_metric_o (best_metric)
    );
endmodule

// File: rtl/vit_decoder_chk.sv
// Property checker for vit_decoder_top, attached with bind.
// Assumes it sees the top's ports and a few internal registers.
module vit_decoder_chk #(
    parameter int K  = 7,
    parameter int MW = 8,
    parameter int FW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_load,
    input logic [K-1:0]  cfg_poly_a,
    input logic [K-1:0]  cfg_poly_b,
    input logic [K-1:0]  poly_a_q,
    input logic [K-1:0]  poly_b_q,
    input logic          in_valid,
    input logic          out_valid,
    input logic [MW-1:0] best_metric
);
    logic [MW-1:0] step_q;
    logic [MW-1:0] prev_best_q;

    // Remember the last best metric to measure its growth.
    always_ff @(posedge clk) prev_best_q <= best_metric;
    assign step_q = best_metric - prev_best_q;

    // R3: a load strobe lands both generators.
    p_cfg_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (poly_a_q == $past(cfg_poly_a)) && (poly_b_q == $past(cfg_poly_b)));

    // R5: reset clears the output and leaves state 0 best at metric 0.
    p_reset_clear_r5: assert property (@(posedge clk)
        !rst_n |=> !out_valid && (best_metric == '0));

    // R6: a decoded bit only follows an accepted pair.
    p_out_after_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R7: an idle cycle produces no output and keeps the metrics.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(best_metric));

    // R8: the smallest metric grows by at most 2 per accepted pair.
    p_metric_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (step_q <= MW'(2)));
endmodule

bind vit_decoder_top vit_decoder_chk #(.K(K), .MW(MW), .FW(FW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .cfg_poly_a  (cfg_poly_a),
    .cfg_poly_b  (cfg_poly_b),
    .poly_a_q    (poly_a_q),
    .poly_b_q    (poly_b_q),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .best_metric (best_metric)
);

// File: tb/vit_decoder_top_tb_top.sv
`timescale 1ns/1ps
module vit_decoder_top_tb_top;
    localparam int LAT = 43;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_load;
    logic [6:0] cfg_poly_a;
    logic [6:0] cfg_poly_b;
    logic       in_valid;
    logic       in_sym_a;
    logic       in_sym_b;
    logic       out_valid;
    logic       out_bit;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    int   acc;
    logic exp_bit;
    logic [5:0] enc_s;
    logic [6:0] ga, gb;
    logic sent[$];

    always #2 clk = ~clk;

    vit_decoder_top #(.MW(6), .BIAS(16)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_poly_a (cfg_poly_a),
        .cfg_poly_b (cfg_poly_b),
        .in_valid   (in_valid),
        .in_sym_a   (in_sym_a),
        .in_sym_b   (in_sym_b),
        .out_valid  (out_valid),
        .out_bit    (out_bit)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: drive at a falling edge, check at the next one.
    task automatic cyc(input logic v, input logic a, input logic b, input logic ld, input string req);
        logic ev;
        in_valid = v; in_sym_a = a; in_sym_b = b; cfg_load = ld;
        ev = 1'b0;
        if (v) begin
            if (acc >= LAT) begin
                ev = 1'b1;
                exp_bit = sent[acc-LAT];
            end
            acc++;
        end
        @(negedge clk);
        check(req, "out_valid", int'(out_valid), int'(ev));
        check(ev ? req : "R7", "out_bit", int'(out_bit), int'(exp_bit));
    endtask

    // Encode one data bit per R1, optionally flip one code bit, and send it.
    task automatic send(input logic u, input int flip, input string req);
        logic [6:0] r;
        logic a, b;
        r = {u, enc_s};
        a = ^(ga & r);
        b = ^(gb & r);
        enc_s = {u, enc_s[5:1]};
        if (flip == 1) a = ~a;
        if (flip == 2) b = ~b;
        sent.push_back(u);
        cyc(1'b1, a, b, 1'b0, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 0; in_sym_a = 0; in_sym_b = 0; cfg_load = 0;
        cfg_poly_a = '0; cfg_poly_b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        acc = 0; exp_bit = 1'b0; enc_s = '0; sent.delete();
        check("R5", "out_valid after reset", int'(out_valid), 0);
        check("R5", "out_bit after reset", int'(out_bit), 0);
    endtask

    initial begin
        @(negedge clk);
        // Phase A: default 171/133 generators, isolated errors, idle gaps.
        ga = 7'o171; gb = 7'o133;
        do_reset();
        for (int i = 0; i < 1500; i++) begin
            int fl;
            fl = 0;
            if (i % 16 == 5) fl = ((i / 16) % 2 == 0) ? 1 : 2;
            send(1'($urandom), fl, "R4 R9 R6 R2 R1");
            if (i % 7 == 3) cyc(1'b0, 1'b1, 1'b1, 1'b0, "R7");
        end
        for (int i = 0; i < LAT + 2; i++) send(1'b0, 0, "R4 R6");

        // Phase B: reprogrammed generators, error-free.
        do_reset();
        cfg_poly_a = 7'o165; cfg_poly_b = 7'o117;
        cyc(1'b0, 1'b0, 1'b0, 1'b1, "R3");
        cfg_poly_a = '0; cfg_poly_b = '0;
        ga = 7'o165; gb = 7'o117;
        for (int i = 0; i < 300; i++) send(1'($urandom), 0, "R10 R3");
        for (int i = 0; i < LAT + 2; i++) send(1'b0, 0, "R10 R6");

        // Phase C: reset restores 171/133 (R3) and the start-up delay (R6).
        do_reset();
        ga = 7'o171; gb = 7'o133;
        for (int i = 0; i < 200; i++) send(1'($urandom), 0, "R3 R6");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule